// File: doc/BRIEF.md
# Serial SRAM Slave Interface

This block is the slave end of a serial memory link in front of a small on-chip byte array. A host selects the block with an active-low select, clocks it with a serial clock, and sends an 8-bit instruction, a 24-bit address (most significant bit first) and then data. A read returns bytes from the array, and a write stores them. The address moves up by one for every byte for as long as select stays low.

The link starts in single-lane mode. In this mode bits enter on lane 0 and leave on lane 1. One instruction widens the link to two lanes and another to four lanes, and a third returns it to single-lane operation. An active-low pause input can freeze a transfer part-way through in the single-lane and two-lane modes. The block keeps its position in the transfer and resumes from that position. Lane direction is shown by a separate output-enable bit for each lane.

All pins are sampled by the system clock, which must run well above the serial clock. The block finds serial clock edges by comparing each sample with the previous one. The array is `2**ADDR_W` bytes, and only the low `ADDR_W` address bits select a byte.

Top module: `serial_sram_slave`

## Requirements
- R1: While `cs_n` is high, every bit of `sio_oe` is 0 and the block is idle. The mode is kept.
- R2: After reset a command is accepted only after `cs_n` has been seen high and then low. If `cs_n` is already low when reset ends, that session is ignored, including mode instructions.
- R3: Input bits are taken on serial clock rising edges. Output bits change only after falling edges. In single-lane mode the instruction, address and data arrive on `sio_in[0]`, and read data leaves MSB first on `sio_out[1]` with `sio_oe` = 4'b0010.
- R4: Opcode 8'h02, a 24-bit address and data bytes write the array, one byte per 8 data bits. A completed byte is stored even when `cs_n` rises right after its last bit. A byte cut short by `cs_n` rising is discarded.
- R5: Opcode 8'h03 and a 24-bit address start a read. The first data bits appear after the falling edge that follows the last address bit. Later bytes come from successive addresses.
- R6: Only the low `ADDR_W` address bits are used. Auto-increment wraps from the top byte to byte 0.
- R7: Opcode 8'h3B selects two lanes (`sio_in[1]`/`sio_out[1]` carry the more significant bit, `sio_oe` = 4'b0011). Opcode 8'h38 selects four lanes (lane 3 most significant, `sio_oe` = 4'b1111). Opcode 8'hFF returns to single lane. The opcodes themselves are sent at the current width, and the mode lasts across sessions.
- R8: `hold_n` low while the serial clock is low pauses the transfer at once. During the pause, clock edges and input data are ignored and the bit position is kept.
- R9: If `hold_n` falls while the serial clock is high, the pause begins at the next falling edge. That falling edge is still acted on.
- R10: `hold_n` low forces `sio_oe` to 0 immediately, whatever the serial clock level.
- R11: The pause ends only once `hold_n` is high while the serial clock is low. A falling edge that completes the exit is not acted on.
- R12: In four-lane mode `hold_n` has no effect.
- R13: An unknown opcode makes the block ignore the rest of the session. The array is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock from the host |
| hold_n | input | 1 | Active-low pause request |
| sio_in | input | 4 | Data lanes driven by the host |
| sio_out | output | 4 | Data lanes driven by the block |
| sio_oe | output | 4 | Output enable for each lane |

## Verification
The assertions check the following on every cycle:
- deselect always returns the block to idle;
- the outgoing shift register moves only on accepted falling edges, and the incoming one only on accepted rising edges;
- while paused and selected, the bit counter stays frozen;
- a pause exists only in a selected session and never in four-lane mode;
- a byte commit lasts exactly one cycle.

Only the directed scenarios can show the end-to-end behaviour:
- that data written at one lane width reads back correctly;
- that the address wraps;
- that the deferred pause entry and the pause exit during a high clock keep the read bit stream intact;
- that unknown opcodes and unarmed sessions leave the array and the mode untouched.

// File: rtl/serial_sram_slave.sv
module serial_sram_slave #(
  parameter int ADDR_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       hold_n,
  input  logic [3:0] sio_in,
  output logic [3:0] sio_out,
  output logic [3:0] sio_oe
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_DUAL   = 8'h3B;
  localparam logic [7:0] OP_QUAD   = 8'h38;
  localparam logic [7:0] OP_SINGLE = 8'hFF;

  typedef enum logic [2:0] {PH_IDLE, PH_CMD, PH_ADDR, PH_RD, PH_WR, PH_SKIP} phase_t;
  typedef enum logic [1:0] {LN_1, LN_2, LN_4} lanes_t;

  logic [7:0]        mem [DEPTH];
  phase_t            phase;
  lanes_t            mode;
  logic              cs_q, sck_q, held_r, drv_r, wr_pend, is_rd;
  logic [4:0]        bcnt;
  logic [3:0]        ocnt;
  logic [23:0]       sh;
  logic [7:0]        obuf, wdata;
  logic [ADDR_W-1:0] addr, waddr;

  logic [2:0]  step;
  logic [3:0]  in_mask, lane_mask, out_lanes;
  logic [23:0] sh_nx;
  logic [5:0]  cnt_nx;

  wire selected  = !cs_n && phase != PH_IDLE;
  wire cs_fall   = cs_q && !cs_n;
  wire sck_rise  = selected && !held_r && sck && !sck_q;
  wire sck_fall  = selected && !held_r && !sck && sck_q;
  wire pause_pin = !hold_n && mode != LN_4;
  wire drive     = selected && phase == PH_RD && drv_r && !held_r && !pause_pin;

  always_comb begin
    case (mode)
      LN_2: begin
        step = 3'd2; in_mask = 4'b0011; lane_mask = 4'b0011; out_lanes = {2'b00, obuf[7:6]};
      end
      LN_4: begin
        step = 3'd4; in_mask = 4'b1111; lane_mask = 4'b1111; out_lanes = obuf[7:4];
      end
      default: begin
        step = 3'd1; in_mask = 4'b0001; lane_mask = 4'b0010; out_lanes = {2'b00, obuf[7], 1'b0};
      end
    endcase
  end

  assign sh_nx   = (sh << step) | {20'd0, sio_in & in_mask};
  assign cnt_nx  = {1'b0, bcnt} + {3'd0, step};
  assign sio_oe  = drive ? lane_mask : 4'b0000;
  assign sio_out = drive ? out_lanes : 4'b0000;

  always_ff @(posedge clk) begin
    if (wr_pend) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b0;
      sck_q   <= 1'b0;
      held_r  <= 1'b0;
      drv_r   <= 1'b0;
      wr_pend <= 1'b0;
      is_rd   <= 1'b0;
      phase   <= PH_IDLE;
      mode    <= LN_1;
      bcnt    <= '0;
      ocnt    <= '0;
      sh      <= '0;
      obuf    <= '0;
      wdata   <= '0;
      addr    <= '0;
      waddr   <= '0;
    end else begin
      cs_q    <= cs_n;
      sck_q   <= sck;
      wr_pend <= 1'b0;
      if (cs_n || phase == PH_IDLE || mode == LN_4) held_r <= 1'b0;
      else if (!sck) held_r <= !hold_n;

      if (cs_n) begin
        phase <= PH_IDLE;
        drv_r <= 1'b0;
      end else if (cs_fall) begin
        phase <= PH_CMD;
        bcnt  <= '0;
        drv_r <= 1'b0;
      end else if (sck_rise) begin
        sh <= sh_nx;
        case (phase)
          PH_CMD: begin
            if (cnt_nx == 6'd8) begin
              bcnt <= '0;
              case (sh_nx[7:0])
                OP_READ:   begin phase <= PH_ADDR; is_rd <= 1'b1; end
                OP_WRITE:  begin phase <= PH_ADDR; is_rd <= 1'b0; end
                OP_DUAL:   begin phase <= PH_SKIP; mode <= LN_2; end
                OP_QUAD:   begin phase <= PH_SKIP; mode <= LN_4; end
                OP_SINGLE: begin phase <= PH_SKIP; mode <= LN_1; end
                default:   phase <= PH_SKIP;
              endcase
            end else bcnt <= cnt_nx[4:0];
          end
          PH_ADDR: begin
            if (cnt_nx == 6'd24) begin
              bcnt  <= '0;
              addr  <= sh_nx[ADDR_W-1:0];
              ocnt  <= '0;
              phase <= is_rd ? PH_RD : PH_WR;
            end else bcnt <= cnt_nx[4:0];
          end
          PH_WR: begin
            if (cnt_nx == 6'd8) begin
              bcnt    <= '0;
              wr_pend <= 1'b1;
              wdata   <= sh_nx[7:0];
              waddr   <= addr;
              addr    <= addr + 1'b1;
            end else bcnt <= cnt_nx[4:0];
          end
          default: ;
        endcase
      end else if (sck_fall && phase == PH_RD) begin
        if (ocnt == 4'd0) begin
          obuf  <= mem[addr];
          addr  <= addr + 1'b1;
          ocnt  <= 4'd8 - {1'b0, step};
          drv_r <= 1'b1;
        end else begin
          obuf <= obuf << step;
          ocnt <= ocnt - {1'b0, step};
        end
      end
    end
  end

  AST_IDLE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> phase == PH_IDLE); // R1
  AST_OBUF_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(obuf)); // R3
  AST_SHIFT_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> $stable(sh)); // R3
  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> !wr_pend); // R4
  AST_PAUSE_FREEZES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (held_r && !cs_n) |=> $stable(bcnt)); // R8
  AST_PAUSE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    held_r |-> $past(!cs_n)); // R8
  AST_QUAD_NEVER_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    mode == LN_4 |-> !held_r); // R12

endmodule

// File: tb/tb_serial_sram_slave.sv
module tb_serial_sram_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b0;
  logic       sck = 1'b0;
  logic       hold_n = 1'b1;
  logic [3:0] sio_in = 4'd0;
  logic [3:0] sio_out, sio_oe;

  int tests = 0;
  int fails = 0;
  int bw = 1;
  bit done = 1'b0;

  serial_sram_slave #(.ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe)
  );

  always #2 clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] oe_mask();
    return (bw == 4) ? 4'b1111 : (bw == 2) ? 4'b0011 : 4'b0010;
  endfunction

  function automatic logic [3:0] take(input logic [3:0] d);
    return (bw == 4) ? d : (bw == 2) ? {2'b00, d[1:0]} : {3'b000, d[1]};
  endfunction

  task automatic pulse(input logic [3:0] din, output logic [3:0] dout, output logic [3:0] oe);
    sio_in = din;
    wait_clk(3);
    dout = sio_out;
    oe = sio_oe;
    sck = 1'b1;
    wait_clk(4);
    sck = 1'b0;
    wait_clk(4);
  endtask

  task automatic send(input logic [31:0] v, input int nbits);
    logic [3:0] d, o;
    for (int i = nbits - bw; i >= 0; i -= bw)
      pulse(4'((v >> i) & ((32'd1 << bw) - 1)), d, o);
  endtask

  task automatic recv(output logic [7:0] b, output bit oe_ok);
    logic [3:0] d, o;
    b = 8'd0;
    oe_ok = 1'b1;
    for (int i = 0; i < 8 / bw; i++) begin
      pulse(4'd0, d, o);
      b = (b << bw) | 8'(take(d));
      if (o !== oe_mask()) oe_ok = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic desel();
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic do_write(input logic [23:0] a, input logic [31:0] d, input int n);
    sel();
    send(32'h02, 8);
    send({8'd0, a}, 24);
    for (int k = 0; k < n; k++) send(32'((d >> (8 * (n - 1 - k))) & 32'hFF), 8);
    desel();
  endtask

  task automatic do_read(input logic [23:0] a, input int n, output logic [31:0] q, output bit oe_ok);
    logic [7:0] b;
    bit ok;
    q = 32'd0;
    oe_ok = 1'b1;
    sel();
    send(32'h03, 8);
    send({8'd0, a}, 24);
    for (int k = 0; k < n; k++) begin
      recv(b, ok);
      q = (q << 8) | 32'(b);
      if (!ok) oe_ok = 1'b0;
    end
    desel();
  endtask

  task automatic t_reset_and_unarmed();
    logic [31:0] q;
    bit ok;
    check(sio_oe == 4'b0000, "R1 oe after reset", 32'(sio_oe), 0);
    send(32'h38, 8);
    check(sio_oe == 4'b0000, "R2 unarmed session drives nothing", 32'(sio_oe), 0);
    cs_n = 1'b1;
    wait_clk(4);
    check(sio_oe == 4'b0000, "R1 oe while deselected", 32'(sio_oe), 0);
    do_write(24'h000030, 32'h96, 1);
    do_read(24'h000030, 1, q, ok);
    check(q == 32'h96, "R2 mode unchanged by unarmed session", q, 32'h96);
    check(ok, "R3 single-lane oe mask", 0, 32'h2);
  endtask

  task automatic t_single_burst();
    logic [31:0] q;
    bit ok;
    do_write(24'h000020, 32'hDEADBEEF, 4);
    do_read(24'h000020, 4, q, ok);
    check(q == 32'hDEADBEEF, "R4 R5 burst write and read", q, 32'hDEADBEEF);
    check(ok, "R3 oe mask during read", 0, 32'h2);
    check(sio_oe == 4'b0000, "R1 oe after read session", 32'(sio_oe), 0);
  endtask

  task automatic t_wrap();
    logic [31:0] q;
    bit ok;
    do_write(24'h0000FF, 32'h5AC3, 2);
    do_read(24'h000000, 1, q, ok);
    check(q == 32'hC3, "R6 write wraps to zero", q, 32'hC3);
    do_read(24'hAB00FF, 2, q, ok);
    check(q == 32'h5AC3, "R6 upper bits ignored and read wraps", q, 32'h5AC3);
  endtask

  task automatic t_cs_cut();
    logic [31:0] q;
    bit ok;
    do_write(24'h000050, 32'hAABB, 2);
    sel();
    send(32'h02, 8);
    send(32'h000050, 24);
    send(32'h3C, 8);
    send(32'hF, 4);
    desel();
    do_read(24'h000050, 2, q, ok);
    check(q == 32'h3CBB, "R4 partial byte discarded", q, 32'h3CBB);
    sel();
    send(32'h02, 8);
    send(32'h000060, 24);
    send(32'h3F, 7);
    sio_in = 4'd0;
    wait_clk(3);
    sck = 1'b1;
    wait_clk(1);
    cs_n = 1'b1;
    wait_clk(3);
    sck = 1'b0;
    wait_clk(4);
    do_read(24'h000060, 1, q, ok);
    check(q == 32'h7E, "R4 byte completes across deselect", q, 32'h7E);
  endtask

  task automatic t_unknown();
    logic [31:0] q;
    bit ok;
    sel();
    send(32'h55, 8);
    send(32'h000030, 24);
    send(32'h00, 8);
    desel();
    do_read(24'h000030, 1, q, ok);
    check(q == 32'h96, "R13 unknown opcode leaves array", q, 32'h96);
  endtask

  task automatic t_pause_write();
    logic [31:0] q;
    logic [3:0] d, o;
    bit ok;
    sel();
    send(32'h02, 8);
    send(32'h000070, 24);
    send(32'hA, 4);
    hold_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < 3; i++) pulse(4'd1, d, o);
    hold_n = 1'b1;
    wait_clk(4);
    send(32'h6, 4);
    desel();
    do_read(24'h000070, 1, q, ok);
    check(q == 32'hA6, "R8 pause keeps bit position on write", q, 32'hA6);
  endtask

  task automatic t_pause_read();
    logic [31:0] q;
    logic [7:0] b;
    logic [3:0] d, o;
    bit ok;
    do_write(24'h000078, 32'hB4, 1);
    sel();
    send(32'h03, 8);
    send(32'h000078, 24);
    b = 8'd0;
    for (int i = 0; i < 4; i++) begin
      pulse(4'd0, d, o);
      b = {b[6:0], d[1]};
    end
    sio_in = 4'd0;
    wait_clk(3);
    b = {b[6:0], sio_out[1]};
    sck = 1'b1;
    wait_clk(2);
    hold_n = 1'b0;
    wait_clk(1);
    check(sio_oe == 4'b0000, "R10 hold with clock high forces hi-z", 32'(sio_oe), 0);
    wait_clk(1);
    sck = 1'b0;
    wait_clk(4);
    for (int i = 0; i < 2; i++) begin
      pulse(4'd0, d, o);
      check(o == 4'b0000, "R8 no drive while paused", 32'(o), 0);
    end
    sck = 1'b1;
    wait_clk(2);
    hold_n = 1'b1;
    wait_clk(2);
    check(sio_oe == 4'b0000, "R11 still paused while clock high", 32'(sio_oe), 0);
    sck = 1'b0;
    wait_clk(4);
    for (int i = 0; i < 3; i++) begin
      pulse(4'd0, d, o);
      b = {b[6:0], d[1]};
    end
    desel();
    check(b == 8'hB4, "R9 R11 deferred entry and exit keep stream", 32'(b), 32'hB4);
  endtask

  task automatic t_modes();
    logic [31:0] q;
    logic [7:0] b;
    bit ok;
    sel();
    send(32'h3B, 8);
    desel();
    bw = 2;
    do_write(24'h000090, 32'hC35A, 2);
    do_read(24'h000090, 2, q, ok);
    check(q == 32'hC35A, "R7 dual-lane data", q, 32'hC35A);
    check(ok, "R7 dual-lane oe mask", 0, 32'h3);
    sel();
    send(32'h38, 8);
    desel();
    bw = 4;
    do_write(24'h0000A0, 32'h1E2D, 2);
    sel();
    send(32'h03, 8);
    send(32'h0000A0, 24);
    recv(b, ok);
    check(b == 8'h1E && ok, "R7 quad-lane first byte and oe", 32'(b), 32'h1E);
    hold_n = 1'b0;
    recv(b, ok);
    check(b == 8'h2D && ok, "R12 hold ignored in quad", 32'(b), 32'h2D);
    hold_n = 1'b1;
    desel();
    sel();
    send(32'hFF, 8);
    desel();
    bw = 1;
    do_read(24'h000030, 1, q, ok);
    check(q == 32'h96 && ok, "R7 back to single lane", q, 32'h96);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset_and_unarmed();
    t_single_burst();
    t_wrap();
    t_cs_cut();
    t_unknown();
    t_pause_write();
    t_pause_read();
    t_modes();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule